// File: doc/BRIEF.md
# Sequential Compare-Swap Sorter

This block keeps a fixed number of signed words in a register array and puts them in order by exchanging neighbours, one pair per clock cycle. A pass walks a compare pointer from the leftmost slot to the right. Each pass fixes the value at the right end of the still-unsorted region, so the next pass stops one slot earlier. A full sort of N words takes N-1 passes and N(N-1)/2 cycles.

The array is loaded in parallel while the block is idle. A start pulse then begins the sort. The direction input is sampled at that moment. While the sort runs, busy is high and the array contents are visible at the output. A one-cycle done pulse marks the end of the sort. Neighbour order is decided from the sign of a one-bit-wider subtraction, so the extreme codes compare correctly. An elaboration-time option lets the sort stop after the first pass that makes no exchange.

Top module: `bsort_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are 0 and every word of sorted_data is 0.
- R2: When busy is low and load is high, the word on load_data[i*W +: W] appears at sorted_data[i*W +: W] on the next cycle, and a start in that same cycle is ignored. A load while busy is high changes nothing.
- R3: With descend low at start, the final output is non-decreasing from slot 0 to slot N-1, with words read as W-bit two's complement.
- R4: With descend high at start, the final output is non-increasing from slot 0 to slot N-1.
- R5: Order is decided correctly across the full signed range, including the most negative code against the most positive code. Equal words are never exchanged.
- R6: Each busy cycle compares exactly one pair. In pass p (counting from 1), the pairs are (0,1), (1,2) and so on up to (N-1-p, N-p), in that order. The pair is exchanged only when its two words are out of order for the selected direction.
- R7: busy rises the cycle after an accepted start. With early stop off, busy falls after exactly N(N-1)/2 cycles. done is high for exactly that one cycle, the first cycle with busy low.
- R8: A start pulse while busy is high has no effect on the schedule or the data.
- R9: While idle, sorted_data stays unchanged until the next load or sort, whatever descend does.
- R10: With EARLY_EXIT set, the sort ends after the first pass that makes no exchange. Already-ordered input finishes in N-1 cycles. No sort takes more than N(N-1)/2 cycles.
- R11: Changing descend while busy does not alter the direction of the running sort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture load_data into the array while idle |
| load_data | input | N*W | Words to sort, slot i at bits [i*W +: W] |
| start | input | 1 | Begin a sort while idle |
| descend | input | 1 | 0 = ascending, 1 = descending, sampled at start |
| busy | output | 1 | A sort is in progress |
| done | output | 1 | One-cycle pulse after the last compare |
| sorted_data | output | N*W | Array contents, slot i at bits [i*W +: W] |

## Verification
The hardest case to reach from the ports is interference in the middle of a sort. That means start, load and descend changing while the pass counter and pointer are partway through the schedule. The stimulus pulses those inputs on alternating cycles, but only while both instances under test are known to be busy. A model that steps one comparison per cycle is checked against the whole array every clock. This catches any misplaced exchange or window bound at the cycle it happens. A second instance with early stop enabled runs on the same stimulus, fed with already-ordered, all-equal and reversed data, to hit both the shortest and the longest runs.

// File: rtl/bsort_pkg.sv
package bsort_pkg;
  function automatic int pair_total(input int n);
    return (n * (n - 1)) / 2;
  endfunction

  function automatic int cnt_bits(input int n);
    return $clog2(n + 1) + 1;
  endfunction
endpackage

// File: rtl/bsort_cmp.sv
module bsort_cmp #(
  parameter int W = 6
) (
  input  logic [W-1:0] left_i,
  input  logic [W-1:0] right_i,
  input  logic         desc_i,
  output logic         swap_o
);
  logic [W:0] ext_l, ext_r, diff;
  logic       neg, zero;

  always_comb begin
    ext_l  = {left_i[W-1], left_i};
    ext_r  = {right_i[W-1], right_i};
    diff   = ext_l + ~ext_r + {{W{1'b0}}, 1'b1};
    neg    = diff[W];
    zero   = (diff == '0);
    swap_o = desc_i ? neg : (!neg && !zero);
  end

  // R5
  always_comb begin
    equal_noswap_chk: assert (!((left_i == right_i) && swap_o));
  end
endmodule

// File: rtl/bsort_ctrl.sv
module bsort_ctrl #(
  parameter int N          = 8,
  parameter bit EARLY_EXIT = 1'b0,
  parameter int IW         = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          load_i,
  input  logic          desc_i,
  input  logic          swap_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          desc_o,
  output logic [IW-1:0] step_o
);
  import bsort_pkg::*;
  localparam int MAXC = pair_total(N);
  localparam int CW   = cnt_bits(MAXC);

  logic          busy_q, busy_d, done_q, done_d;
  logic          dirty_q, dirty_d, desc_q, desc_d;
  logic [IW-1:0] stage_q, stage_d, step_q, step_d, limit;
  logic          go, last_step, last_stage, finish, en;

  always_comb begin
    go         = !busy_q && start_i && !load_i;
    limit      = IW'(N - 1) - stage_q;
    last_step  = (step_q == limit);
    last_stage = (stage_q == IW'(N - 1));
    finish     = busy_q && last_step &&
                 (last_stage || (EARLY_EXIT && !(dirty_q || swap_i)));
    en         = busy_q || go;
    busy_d     = busy_q ? !finish : go;
    done_d     = finish;
    desc_d     = go ? desc_i : desc_q;
    if (go) begin
      stage_d = IW'(1);
      step_d  = '0;
      dirty_d = 1'b0;
    end else if (last_step) begin
      stage_d = stage_q + IW'(1);
      step_d  = '0;
      dirty_d = 1'b0;
    end else begin
      stage_d = stage_q;
      step_d  = step_q + IW'(1);
      dirty_d = dirty_q || swap_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      step_q  <= '0;
      dirty_q <= 1'b0;
      desc_q  <= 1'b0;
    end else if (en) begin
      stage_q <= stage_d;
      step_q  <= step_d;
      dirty_q <= dirty_d;
      desc_q  <= desc_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign desc_o = desc_q;
  assign step_o = step_q;

  // run length counter used only by the checks below
  logic [CW-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (go)     run_cnt <= '0;
    else if (busy_q) run_cnt <= run_cnt + CW'(1);
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  // R6
  step_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (step_q <= limit));
  // R11
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(desc_q));
  // R10
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (EARLY_EXIT ? (run_cnt <= CW'(MAXC)) : (run_cnt == CW'(MAXC))));
endmodule

// File: rtl/bsort_array.sv
module bsort_array #(
  parameter int N  = 8,
  parameter int W  = 6,
  parameter int IW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [N*W-1:0] load_data_i,
  input  logic           busy_i,
  input  logic           desc_i,
  input  logic [IW-1:0]  step_i,
  output logic           swap_o,
  output logic [N*W-1:0] data_o
);
  logic [W-1:0]  arr_q [N];
  logic [W-1:0]  left_w, right_w;
  logic [IW-1:0] nxt_idx;
  logic          load_ok, xchg;

  assign nxt_idx = step_i + IW'(1);
  assign left_w  = arr_q[step_i];
  assign right_w = arr_q[nxt_idx];
  assign load_ok = load_i && !busy_i;
  assign xchg    = busy_i && swap_o;

  bsort_cmp #(.W(W)) u_cmp (
    .left_i (left_w),
    .right_i(right_w),
    .desc_i (desc_i),
    .swap_o (swap_o)
  );

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [W-1:0] nxt;
    logic         hit_l, hit_r, en;
    always_comb begin
      hit_l = (step_i == IW'(i));
      if (i > 0) hit_r = (step_i == IW'(i - 1));
      else       hit_r = 1'b0;
      en = load_ok || (xchg && (hit_l || hit_r));
      if (load_ok)    nxt = load_data_i[i*W +: W];
      else if (hit_l) nxt = right_w;
      else            nxt = left_w;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  arr_q[i] <= '0;
      else if (en) arr_q[i] <= nxt;
    end
    assign data_o[i*W +: W] = arr_q[i];
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && !load_i) |=> $stable(data_o));
endmodule

// File: rtl/bsort_seq.sv
module bsort_seq #(
  parameter int N          = 8,
  parameter int W          = 6,
  parameter bit EARLY_EXIT = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [N*W-1:0] load_data,
  input  logic           start,
  input  logic           descend,
  output logic           busy,
  output logic           done,
  output logic [N*W-1:0] sorted_data
);
  localparam int IW = $clog2(N);

  logic          swap_w, desc_w;
  logic [IW-1:0] step_w;

  bsort_ctrl #(.N(N), .EARLY_EXIT(EARLY_EXIT), .IW(IW)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start),
    .load_i (load),
    .desc_i (descend),
    .swap_i (swap_w),
    .busy_o (busy),
    .done_o (done),
    .desc_o (desc_w),
    .step_o (step_w)
  );

  bsort_array #(.N(N), .W(W), .IW(IW)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_data_i(load_data),
    .busy_i     (busy),
    .desc_i     (desc_w),
    .step_i     (step_w),
    .swap_o     (swap_w),
    .data_o     (sorted_data)
  );
endmodule

// File: tb/bsort_seq_tb.sv
`timescale 1ns/1ps
module bsort_seq_tb;
  localparam int N  = 8;
  localparam int W  = 6;
  localparam int NW = N * W;
  localparam int FULL = N * (N - 1) / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0, start = 1'b0, descend = 1'b0;
  logic [NW-1:0] load_data = '0;
  logic          busy0, done0, busy1, done1;
  logic [NW-1:0] data0, data1;

  always #2 clk = ~clk;

  bsort_seq #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
    .start(start), .descend(descend), .busy(busy0), .done(done0),
    .sorted_data(data0));

  bsort_seq #(.N(N), .W(W), .EARLY_EXIT(1'b1)) u_dut_ee (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
    .start(start), .descend(descend), .busy(busy1), .done(done1),
    .sorted_data(data1));

  int    checks = 0, errors = 0;
  bit    finished = 0;
  string tag = "R6";

  // behavioural reference, index 0 = plain, 1 = early stop
  int mv [2][N];
  bit mbusy [2], mdone [2], mswp [2], mdesc [2];
  int mstage [2], mstep [2];
  int cnt0, cnt1;

  task automatic chk(input string t, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", t, what, act, exp);
    end
  endtask

  task automatic chk_vec(input string t, input string what, input logic [NW-1:0] act,
                         input logic [NW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", t, what, act, exp);
    end
  endtask

  function automatic logic [NW-1:0] pack(input int v [N]);
    logic [NW-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = W'(v[i]);
    return r;
  endfunction

  function automatic logic [NW-1:0] pack_model(input int k);
    logic [NW-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = W'(mv[k][i]);
    return r;
  endfunction

  task automatic model_step(input bit ld, input logic [NW-1:0] d, input bit st, input bit dsc);
    for (int k = 0; k < 2; k++) begin
      mdone[k] = 0;
      if (mbusy[k]) begin
        int a, b;
        bit sw;
        a  = mv[k][mstep[k]];
        b  = mv[k][mstep[k] + 1];
        sw = mdesc[k] ? (a < b) : (a > b);
        if (sw) begin
          mv[k][mstep[k]] = b;
          mv[k][mstep[k] + 1] = a;
          mswp[k] = 1;
        end
        if (mstep[k] == N - 1 - mstage[k]) begin
          if (mstage[k] == N - 1 || (k == 1 && !mswp[k])) begin
            mbusy[k] = 0;
            mdone[k] = 1;
          end else begin
            mstage[k]++;
            mstep[k] = 0;
            mswp[k] = 0;
          end
        end else mstep[k]++;
      end else if (ld) begin
        for (int i = 0; i < N; i++) mv[k][i] = int'($signed(d[i*W +: W]));
      end else if (st) begin
        mbusy[k] = 1; mstage[k] = 1; mstep[k] = 0; mswp[k] = 0; mdesc[k] = dsc;
      end
    end
  endtask

  task automatic compare_all();
    chk(tag, "busy", busy0, mbusy[0]);
    chk(tag, "done", done0, mdone[0]);
    chk_vec(tag, "array", data0, pack_model(0));
    chk(tag, "busy(early)", busy1, mbusy[1]);
    chk(tag, "done(early)", done1, mdone[1]);
    chk_vec(tag, "array(early)", data1, pack_model(1));
  endtask

  task automatic cyc(input bit ld, input logic [NW-1:0] d, input bit st, input bit dsc);
    @(negedge clk);
    load = ld; load_data = d; start = st; descend = dsc;
    @(posedge clk);
    #1;
    model_step(ld, d, st, dsc);
    compare_all();
  endtask

  function automatic logic [NW-1:0] ordered(input int v [N], input bit dsc);
    int s [N];
    s = v;
    for (int i = 1; i < N; i++) begin
      int key, j;
      key = s[i];
      j = i - 1;
      while (j >= 0 && (dsc ? (s[j] < key) : (s[j] > key))) begin
        s[j + 1] = s[j];
        j--;
      end
      s[j + 1] = key;
    end
    return pack(s);
  endfunction

  task automatic run_sort(input int v [N], input bit dsc, input bit meddle);
    cyc(1'b1, pack(v), 1'b0, dsc);
    cyc(1'b0, '0, 1'b1, dsc);
    cnt0 = -1; cnt1 = -1;
    for (int i = 1; i <= 60; i++) begin
      if (meddle && mbusy[0] && mbusy[1])
        cyc((i % 3) == 0, {NW{1'b1}}, (i % 2) == 0, dsc ^ (i % 2 == 1));
      else
        cyc(1'b0, '0, 1'b0, dsc);
      if (done0 && cnt0 < 0) cnt0 = i;
      if (done1 && cnt1 < 0) cnt1 = i;
      if (cnt0 >= 0 && cnt1 >= 0 && !mbusy[0] && !mbusy[1]) break;
    end
    chk_vec(dsc ? "R4" : "R3", "final order", data0, ordered(v, dsc));
    chk_vec(dsc ? "R4" : "R3", "final order(early)", data1, ordered(v, dsc));
    chk("R7", "cycles to done", cnt0, FULL);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      finished = 1;
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < N; i++) mv[k][i] = 0;
      mbusy[k] = 0; mdone[k] = 0; mswp[k] = 0; mdesc[k] = 0;
      mstage[k] = 0; mstep[k] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "busy in reset", busy0, 0);
    chk("R1", "done in reset", done0, 0);
    chk_vec("R1", "data in reset", data0, '0);
    rst_n = 1'b1;
    tag = "R1";
    cyc(1'b0, '0, 1'b0, 1'b0);
    cyc(1'b0, '0, 1'b1, 1'b0);  // R2: start with nothing loaded sorts zeros
    for (int i = 0; i < FULL; i++) cyc(1'b0, '0, 1'b0, 1'b0);

    // R3 ascending with mixed signs and duplicates
    tag = "R6";
    run_sort('{3, -1, 1, -4, 4, 2, 3, 1}, 1'b0, 1'b0);
    // R4 descending
    run_sort('{-2, -1, -3, -4, 4, 1, 2, 3}, 1'b1, 1'b0);
    // R5 range extremes
    tag = "R5";
    run_sort('{31, -32, 0, -1, 31, -32, 1, -31}, 1'b0, 1'b0);
    run_sort('{-32, 31, -1, 0, -32, 31, -31, 1}, 1'b1, 1'b0);
    // R10 all equal and already ordered: early stop after one pass
    tag = "R10";
    run_sort('{5, 5, 5, 5, 5, 5, 5, 5}, 1'b0, 1'b0);
    chk("R10", "early cycles equal", cnt1, N - 1);
    run_sort('{-9, -3, 0, 0, 2, 7, 20, 31}, 1'b0, 1'b0);
    chk("R10", "early cycles ordered", cnt1, N - 1);
    run_sort('{31, 20, 7, 2, 0, -3, -9, -32}, 1'b0, 1'b0);
    chk("R10", "early cycles reversed", cnt1, FULL);
    // R8 R11 R2: start, load, descend toggled while busy
    tag = "R8";
    run_sort('{12, -7, 0, 30, -30, 5, 5, -1}, 1'b0, 1'b1);
    tag = "R11";
    run_sort('{12, -7, 0, 30, -30, 5, 5, -1}, 1'b1, 1'b1);
    // R9 idle hold while descend moves
    tag = "R9";
    begin
      logic [NW-1:0] held;
      held = data0;
      for (int i = 0; i < 6; i++) cyc(1'b0, '0, 1'b0, i[0]);
      chk_vec("R9", "held output", data0, held);
    end
    // R2 load while idle appears next cycle
    tag = "R2";
    cyc(1'b1, pack('{1, 2, 3, 4, -5, -6, 7, 8}), 1'b1, 1'b0);
    chk_vec("R2", "loaded data", data0, pack('{1, 2, 3, 4, -5, -6, 7, 8}));
    chk("R2", "start ignored with load", busy0, 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule